// File: doc/BRIEF.md
# UART Receive Status and Error-Tagged Receive Queue

This block sits between a serial receiver front end and the CPU-facing register decoder of a 16550-style UART. Each received character arrives with its own parity, framing and break indications. The block stores the character together with these tags. In queued mode the store is a FIFO with `DEPTH` entries (16 by default). In single mode it is a one-entry holding register. The CPU reads the oldest character through a pop strobe.

The block assembles an eight-bit line status byte. The byte carries data-ready, the sticky overrun flag, the error tags of the character that is currently oldest, the two transmitter-empty indications and a summary flag for errors anywhere in the queue. A status-read strobe clears the error indications. The transmitter side does not live here: the occupancy of the transmit holding register or transmit FIFO and the shift-register activity come in as plain inputs. A receiver line status interrupt is raised from the error bits when it is enabled.

Top module: `uart_lsr_core`

## Requirements
- R1: Accepted characters are returned on `rx_char` in arrival order, and `rd_data` removes the oldest one. Storage holds `DEPTH` characters when `fifo_en`=1 and one character when `fifo_en`=0. A character arriving while storage is full is still accepted if `rd_data` removes one in the same cycle.
- R2: `lsr` bit 0 is 1 from the cycle after the first character is accepted. It stays 1 until storage is empty.
- R3: A character that arrives while storage is full, with no removal in that cycle, sets `lsr` bit 1 (overrun) in the next cycle. The stored characters are kept unchanged, and the dropped character is never returned.
- R4: `lsr` bits 2 (parity), 3 (framing) and 4 (break) show the tags of the oldest stored character only. The tags of later characters appear only once those characters become the oldest.
- R5: A `rd_lsr` pulse clears bits 1 to 4 from the next cycle. Tags already reported for the current oldest character stay hidden until that character is removed.
- R6: If an overrun, or a tagged character reaching an empty store, falls in the same cycle as `rd_lsr`, the new indication survives and is visible after that cycle.
- R7: `lsr` bit 7 is 1 only when `fifo_en`=1 and some stored character carries a tag that has not yet been reported. In single mode it is 0.
- R8: `rls_irq` is 1 exactly when `rls_ie`=1 and any of `lsr` bits 1 to 4 is 1.
- R9: With `fifo_en`=0, `lsr` bit 5 (THRE) clears after a `thr_wr` pulse and sets after a `thr_load` pulse. If both pulse in the same cycle, the write wins.
- R10: With `fifo_en`=1, `lsr` bit 5 follows `tx_fifo_empty`.
- R11: `lsr` bit 6 (TEMT) is 1 only when bit 5 is 1 and `tsr_busy` is 0.
- R12: After reset, `lsr` reads 8'h60, storage is empty and `rls_irq` is 0.
- R13: A change of `fifo_en` empties the storage. Once the changed value has been sampled, `lsr` bit 0 is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 selects queued mode, 0 selects single holding register |
| rx_valid | input | 1 | One-cycle strobe: a received character is offered |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error tag of the offered character |
| rx_ferr | input | 1 | Framing error tag of the offered character |
| rx_brk | input | 1 | Break tag of the offered character |
| rd_data | input | 1 | CPU removes the oldest character |
| rd_lsr | input | 1 | CPU reads the status byte |
| rls_ie | input | 1 | Receiver line status interrupt enable |
| thr_wr | input | 1 | CPU writes the transmit holding register |
| thr_load | input | 1 | Holding register moved into the shift register |
| tx_fifo_empty | input | 1 | Transmit FIFO empty (queued mode) |
| tsr_busy | input | 1 | Transmit shift register holds a character |
| rx_char | output | 8 | Oldest stored character |
| lsr | output | 8 | Line status byte |
| rls_irq | output | 1 | Receiver line status interrupt |

## Verification
The assertions assume that strobes such as `rd_data` and `rd_lsr` are single-cycle pulses that arrive with all other inputs settled between clock edges. The overrun and data-ready properties also assume that `fifo_en` is held stable around the cycle they judge. The stimulus changes inputs only a short time after each rising edge and returns every strobe to 0 after one cycle. It switches modes only while no character is offered, so a push is never lost to a flush. Removal is requested only when the bench's own model says a character is stored.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;

    localparam int DATA_W = 8;

    // status byte bit positions (decoded by the CPU register map)
    localparam int LSR_DR   = 0;
    localparam int LSR_OE   = 1;
    localparam int LSR_PE   = 2;
    localparam int LSR_FE   = 3;
    localparam int LSR_BI   = 4;
    localparam int LSR_THRE = 5;
    localparam int LSR_TEMT = 6;
    localparam int LSR_ERRQ = 7;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_entry_t;

    function automatic logic entry_tagged(rx_entry_t e);
        return e.perr | e.ferr | e.brk;
    endfunction

endpackage

// File: rtl/uart_rx_store.sv
module uart_rx_store
    import uart_lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          one_deep,
    input  logic                          push,
    input  logic                          pop,
    input  rx_entry_t                     wr_entry,
    output rx_entry_t                     head,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic [$clog2(DEPTH+1)-1:0]    tag_cnt,
    output logic                          full,
    output logic                          pop_ok,
    output logic                          drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             accept;
    logic             push_tag, pop_tag;

    assign full     = (count == (one_deep ? CNT_W'(1) : CNT_W'(DEPTH)));
    assign pop_ok   = pop && (count != '0) && !flush;
    assign accept   = push && !flush && (!full || pop_ok);
    assign drop     = push && !flush && full && !pop_ok;
    assign head     = mem[rd_ptr];
    assign push_tag = accept && entry_tagged(wr_entry);
    assign pop_tag  = pop_ok && entry_tagged(head);

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            tag_cnt <= '0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            count   <= count + CNT_W'(accept) - CNT_W'(pop_ok);
            tag_cnt <= tag_cnt + CNT_W'(push_tag) - CNT_W'(pop_tag);
        end
    end

endmodule

// File: rtl/uart_err_flags.sv
module uart_err_flags (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic rd_lsr,
    input  logic drop,
    input  logic pop_ok,
    input  logic have_data,
    output logic overrun,
    output logic head_seen
);
    // overrun: a new drop beats a concurrent status read
    always_ff @(posedge clk) begin
        if (rst)         overrun <= 1'b0;
        else if (drop)   overrun <= 1'b1;
        else if (rd_lsr) overrun <= 1'b0;
    end

    // head_seen hides the tags of an already-reported head character
    always_ff @(posedge clk) begin
        if (rst || flush || pop_ok || !have_data) head_seen <= 1'b0;
        else if (rd_lsr)                          head_seen <= 1'b1;
    end

endmodule

// File: rtl/uart_tx_empty.sv
module uart_tx_empty (
    input  logic clk,
    input  logic rst,
    input  logic fifo_en,
    input  logic thr_wr,
    input  logic thr_load,
    input  logic tx_fifo_empty,
    input  logic tsr_busy,
    output logic thre,
    output logic temt
);
    logic hold_empty;

    always_ff @(posedge clk) begin
        if (rst)           hold_empty <= 1'b1;
        else if (thr_wr)   hold_empty <= 1'b0;
        else if (thr_load) hold_empty <= 1'b1;
    end

    assign thre = fifo_en ? tx_fifo_empty : hold_empty;
    assign temt = thre && !tsr_busy;

endmodule

// File: rtl/uart_lsr_core.sv
module uart_lsr_core
    import uart_lsr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              rx_brk,
    input  logic              rd_data,
    input  logic              rd_lsr,
    input  logic              rls_ie,
    input  logic              thr_wr,
    input  logic              thr_load,
    input  logic              tx_fifo_empty,
    input  logic              tsr_busy,
    output logic [DATA_W-1:0] rx_char,
    output logic [7:0]        lsr,
    output logic              rls_irq
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic             mode_q, flush;
    rx_entry_t        wr_entry, head;
    logic [CNT_W-1:0] rx_count, tag_cnt, unseen_tags;
    logic             rx_full, pop_ok, rx_drop;
    logic             overrun, head_seen, have_data, show_head;
    logic             thre, temt;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= fifo_en;
        else     mode_q <= fifo_en;
    end
    assign flush = !rst && (fifo_en != mode_q);

    assign wr_entry = '{data: rx_data, perr: rx_perr, ferr: rx_ferr, brk: rx_brk};

    uart_rx_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .one_deep (!fifo_en),
        .push     (rx_valid),
        .pop      (rd_data),
        .wr_entry (wr_entry),
        .head     (head),
        .count    (rx_count),
        .tag_cnt  (tag_cnt),
        .full     (rx_full),
        .pop_ok   (pop_ok),
        .drop     (rx_drop)
    );

    assign have_data = (rx_count != '0);

    uart_err_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .rd_lsr    (rd_lsr),
        .drop      (rx_drop),
        .pop_ok    (pop_ok),
        .have_data (have_data),
        .overrun   (overrun),
        .head_seen (head_seen)
    );

    uart_tx_empty u_tx (
        .clk           (clk),
        .rst           (rst),
        .fifo_en       (fifo_en),
        .thr_wr        (thr_wr),
        .thr_load      (thr_load),
        .tx_fifo_empty (tx_fifo_empty),
        .tsr_busy      (tsr_busy),
        .thre          (thre),
        .temt          (temt)
    );

    assign show_head   = have_data && !head_seen;
    assign unseen_tags = tag_cnt - CNT_W'(head_seen && entry_tagged(head));

    always_comb begin
        lsr           = '0;
        lsr[LSR_DR]   = have_data;
        lsr[LSR_OE]   = overrun;
        lsr[LSR_PE]   = show_head && head.perr;
        lsr[LSR_FE]   = show_head && head.ferr;
        lsr[LSR_BI]   = show_head && head.brk;
        lsr[LSR_THRE] = thre;
        lsr[LSR_TEMT] = temt;
        lsr[LSR_ERRQ] = fifo_en && (unseen_tags != '0);
    end

    assign rx_char = have_data ? head.data : '0;
    assign rls_irq = rls_ie && (lsr[LSR_BI:LSR_OE] != '0);

endmodule

// File: rtl/uart_lsr_chk.sv
module uart_lsr_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       fifo_en,
    input logic                       rx_valid,
    input logic                       rd_lsr,
    input logic                       rls_ie,
    input logic [7:0]                 lsr,
    input logic                       rls_irq,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       full,
    input logic                       drop
);
    // R3: a dropped character raises overrun in the following cycle
    a_r3_drop_sets_oe: assert property (@(posedge clk) disable iff (rst)
        drop |=> lsr[1]);

    // R5: a status read without a new drop clears overrun
    a_r5_read_clears_oe: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !drop) |=> !lsr[1]);

    // R1: occupancy never exceeds the configured depth
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= ($clog2(DEPTH+1))'(DEPTH));

    // R1: single mode keeps at most one character
    a_r1_single_depth: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && !$past(fifo_en)) |-> count <= 1);

    // R2: an accepted character makes data ready
    a_r2_arrival_ready: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !full && $stable(fifo_en)) |=> lsr[0]);

    // R8: interrupt is silent while disabled
    a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
        !rls_ie |-> !rls_irq);

    // R11: transmitter empty implies holding side empty
    a_r11_temt_thre: assert property (@(posedge clk) disable iff (rst)
        lsr[6] |-> lsr[5]);

    // R7: error summary only in queued mode
    a_r7_errq_mode: assert property (@(posedge clk) disable iff (rst)
        lsr[7] |-> fifo_en);

endmodule

bind uart_lsr_core uart_lsr_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .rx_valid (rx_valid),
    .rd_lsr   (rd_lsr),
    .rls_ie   (rls_ie),
    .lsr      (lsr),
    .rls_irq  (rls_irq),
    .count    (rx_count),
    .full     (rx_full),
    .drop     (rx_drop)
);

// File: tb/uart_lsr_core_tb.sv
module uart_lsr_core_tb;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic       rd_data = 1'b0, rd_lsr = 1'b0, rls_ie = 1'b0;
    logic       thr_wr = 1'b0, thr_load = 1'b0;
    logic       tx_fifo_empty = 1'b1, tsr_busy = 1'b0;
    logic [7:0] rx_char;
    logic [7:0] lsr;
    logic       rls_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_lsr_core #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk),
        .rd_data(rd_data), .rd_lsr(rd_lsr), .rls_ie(rls_ie),
        .thr_wr(thr_wr), .thr_load(thr_load), .tx_fifo_empty(tx_fifo_empty),
        .tsr_busy(tsr_busy), .rx_char(rx_char), .lsr(lsr), .rls_irq(rls_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
        rx_valid = 1'b1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
        tick();
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [7:0] d);
        check(req, rx_char, d);
        rd_data = 1'b1;
        tick();
        rd_data = 1'b0;
    endtask

    task automatic read_status();
        rd_lsr = 1'b1;
        tick();
        rd_lsr = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        fifo_en = m;
        tick();
        tick();
    endtask

    task automatic t_reset();
        check("R12 lsr", lsr, 8'h60);
        check("R12 irq", rls_irq, 0);
    endtask

    task automatic t_order();
        set_mode(1'b1);
        push(8'hA1, 0, 0, 0);
        check("R2 ready", lsr[0], 1);
        push(8'hB2, 0, 0, 0);
        push(8'hC3, 0, 0, 0);
        pop_expect("R1 first", 8'hA1);
        pop_expect("R1 second", 8'hB2);
        pop_expect("R1 third", 8'hC3);
        check("R2 empty", lsr[0], 0);
    endtask

    task automatic t_tags();
        rls_ie = 1'b1;
        push(8'h01, 0, 0, 0);
        push(8'h02, 1, 0, 0);
        push(8'h03, 0, 1, 1);
        check("R4 clean head", lsr[4:2], 0);
        check("R7 queued tags", lsr[7], 1);
        check("R8 no irq", rls_irq, 0);
        pop_expect("R1 tag a", 8'h01);
        check("R4 parity head", lsr[4:2], 3'b001);
        check("R8 irq", rls_irq, 1);
        read_status();
        check("R5 parity cleared", lsr[4:2], 0);
        check("R7 rest tagged", lsr[7], 1);
        pop_expect("R1 tag b", 8'h02);
        check("R4 frame+break head", lsr[4:2], 3'b110);
        read_status();
        check("R5 fe/bi cleared", lsr[4:2], 0);
        check("R7 all seen", lsr[7], 0);
        check("R8 irq off", rls_irq, 0);
        pop_expect("R1 tag c", 8'h03);
        rls_ie = 1'b0;
    endtask

    task automatic t_overrun();
        for (int i = 0; i < DEPTH; i++) push(8'(i), 0, 0, 0);
        check("R3 no oe when just full", lsr[1], 0);
        push(8'hEE, 0, 0, 0);
        check("R3 oe set", lsr[1], 1);
        for (int i = 0; i < DEPTH; i++) pop_expect("R3 kept data", 8'(i));
        check("R3 dropped absent", lsr[0], 0);
        read_status();
        check("R5 oe cleared", lsr[1], 0);
    endtask

    task automatic t_race();
        for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i), 0, 0, 0);
        rd_lsr = 1'b1;
        push(8'hEE, 0, 0, 0);
        rd_lsr = 1'b0;
        check("R6 oe survives read", lsr[1], 1);
        read_status();
        check("R5 oe cleared later", lsr[1], 0);
        fifo_en = 1'b0;
        tick();
        check("R13 flush", lsr[0], 0);
        set_mode(1'b1);
        rd_lsr = 1'b1;
        push(8'h77, 1, 0, 0);
        rd_lsr = 1'b0;
        check("R6 tag survives read", lsr[2], 1);
        pop_expect("R6 data", 8'h77);
    endtask

    task automatic t_single();
        set_mode(1'b0);
        push(8'h11, 0, 0, 0);
        check("R2 single ready", lsr[0], 1);
        push(8'h22, 0, 0, 0);
        check("R3 single oe", lsr[1], 1);
        pop_expect("R1 single keeps first", 8'h11);
        check("R1 single empty", lsr[0], 0);
        read_status();
        push(8'h33, 1, 0, 0);
        check("R4 single parity", lsr[2], 1);
        check("R7 single no summary", lsr[7], 0);
        pop_expect("R1 single data", 8'h33);
    endtask

    task automatic t_thre_single();
        check("R9 idle thre", lsr[5], 1);
        thr_wr = 1'b1; tick(); thr_wr = 1'b0;
        check("R9 write clears", lsr[5], 0);
        check("R11 temt low", lsr[6], 0);
        tsr_busy = 1'b1;
        thr_load = 1'b1; tick(); thr_load = 1'b0;
        check("R9 load sets", lsr[5], 1);
        check("R11 busy shifter", lsr[6], 0);
        tsr_busy = 1'b0; tick();
        check("R11 both empty", lsr[6], 1);
        thr_wr = 1'b1; thr_load = 1'b1; tick(); thr_wr = 1'b0; thr_load = 1'b0;
        check("R9 write wins", lsr[5], 0);
        thr_load = 1'b1; tick(); thr_load = 1'b0;
    endtask

    task automatic t_thre_fifo();
        set_mode(1'b1);
        tx_fifo_empty = 1'b0; tick();
        check("R10 fifo not empty", lsr[5], 0);
        check("R11 fifo not empty", lsr[6], 0);
        tx_fifo_empty = 1'b1; tick();
        check("R10 fifo empty", lsr[5], 1);
        check("R11 fifo empty", lsr[6], 1);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_order();
        t_tags();
        t_overrun();
        t_race();
        t_single();
        t_thre_single();
        t_thre_fifo();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule